// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space requester and the outbound translation logic of a host bridge. Each request names a bus, a device, a function and a register offset, and says whether it reads or writes. One clock later the block states where the access goes and how:

- whether the access may proceed, and if not, how it completes;
- whether it targets the local register window or the remote configuration window;
- which configuration type to use;
- the value to load into the target field of the outbound translation region;
- the word-aligned register offset, with the write data passed along.

Requests to positions the topology cannot reach are filtered out. A read of such a position completes locally as all ones. A write to it is reported as an error and never reaches the fabric.

A second, independent path takes completions back from the remote window. It substitutes all ones for the returned data whenever the completion reports an error. This way a missing device never shows up as stale or random data. The fabric transaction itself is handled elsewhere.

Top module: `cfgx_xlate`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise. While `rst_n` is low, all response and read-data outputs are zero.
- R2: A request is unreachable in two cases: bus 0 with a device number greater than 1, or bus 1 with a device number greater than 0. Every other bus/device pair is reachable, and the function number never affects reachability.
- R3: An unreachable read responds with `rsp_ones`=1, `rsp_err`=0 and `rsp_access`=0.
- R4: An unreachable write responds with `rsp_err`=1, `rsp_access`=0 and `rsp_ones`=0.
- R5: A reachable request, read or write, responds with `rsp_access`=1, `rsp_err`=0 and `rsp_ones`=0. Exactly one of these three flags is high in every response cycle.
- R6: `rsp_type` is 3'h4 (type 0) for bus numbers 0 and 1, and 3'h5 (type 1) for bus numbers 2 and above.
- R7: `rsp_remote` is 0 (local register window) for bus 0, and 1 (remote configuration window) for any other bus.
- R8: For a remote access, `rsp_target` holds the bus in bits 31:24, the device in bits 23:19, the function in bits 18:16 and zeros in bits 15:0. For bus 0, `rsp_target` is zero.
- R9: `rsp_offset` equals the request offset with bits 1:0 cleared, and `rsp_wdata` equals the request write data.
- R10: `rd_valid` is high in the cycle after `cpl_valid`. `rd_data` is then 32'hFFFF_FFFF if `cpl_err` was high, and `cpl_data` otherwise.
- R11: In a cycle without a request, all response fields other than `rsp_valid` keep their previous values, whatever the request inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_offset | input | 12 | Register offset in bytes |
| req_wdata | input | 32 | Write data |
| cpl_valid | input | 1 | Completion from remote window present |
| cpl_err | input | 1 | Completion reports an error |
| cpl_data | input | 32 | Completion read data |
| rsp_valid | output | 1 | Response present |
| rsp_access | output | 1 | Access proceeds to a window |
| rsp_ones | output | 1 | Read completes locally as all ones |
| rsp_err | output | 1 | Write rejected as unreachable |
| rsp_remote | output | 1 | 1 = remote configuration window, 0 = local register window |
| rsp_type | output | 3 | Configuration type code |
| rsp_target | output | 32 | Outbound translation target value |
| rsp_offset | output | 12 | Word-aligned register offset |
| rsp_wdata | output | 32 | Write data carried with the response |
| rd_valid | output | 1 | Read data returned |
| rd_data | output | 32 | Returned read data, all ones on error |

## Verification
The block has one register stage on each path, so any fault in the filter, the router or the completion merge shows at the ports in the very response that follows the request. It shows up in one of four forms:

- a wrong completion flag;
- a type code on the wrong side of the bus-1 boundary;
- a target field with bits shifted or leaking through on bus 0;
- all ones missing after an errored completion.

A fault in the hold logic shows up one cycle later still, once the request inputs are changed while idle. The sweep therefore covers every device number on the boundary buses and on distant buses, for both reads and writes.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   localparam int unsigned CFG_TYPE_W = 3;
   localparam logic [CFG_TYPE_W-1:0] CFG_TYPE0 = 3'h4;
   localparam logic [CFG_TYPE_W-1:0] CFG_TYPE1 = 3'h5;

   typedef enum logic [1:0] {
      DISP_ACCESS = 2'd0,
      DISP_ONES   = 2'd1,
      DISP_ERROR  = 2'd2
   } disp_e;

endpackage

// File: rtl/cfgx_filter.sv
module cfgx_filter
   import cfgx_pkg::*;
#(
   parameter int unsigned BUS_W        = 8,
   parameter int unsigned DEV_W        = 5,
   parameter bit          FILTER_EN    = 1'b1,
   parameter int unsigned ROOT_DEV_MAX = 1,
   parameter int unsigned LINK_DEV_MAX = 0
) (
   input  logic [BUS_W-1:0] bus,
   input  logic [DEV_W-1:0] dev,
   input  logic             is_write,
   output logic             reachable,
   output disp_e            disp
);

   localparam logic [DEV_W-1:0] ROOT_LIM = DEV_W'(ROOT_DEV_MAX);
   localparam logic [DEV_W-1:0] LINK_LIM = DEV_W'(LINK_DEV_MAX);
   localparam logic [BUS_W-1:0] ROOT_BUS = '0;
   localparam logic [BUS_W-1:0] LINK_BUS = BUS_W'(1);

   generate
      if (ROOT_DEV_MAX >= (1 << DEV_W)) begin : g_bad_root
         $error("cfgx_filter: ROOT_DEV_MAX does not fit DEV_W");
      end
      if (LINK_DEV_MAX >= (1 << DEV_W)) begin : g_bad_link
         $error("cfgx_filter: LINK_DEV_MAX does not fit DEV_W");
      end

      if (FILTER_EN) begin : g_topo
         logic root_miss;
         logic link_miss;
         always_comb begin
            root_miss = (bus == ROOT_BUS) && (dev > ROOT_LIM);
            link_miss = (bus == LINK_BUS) && (dev > LINK_LIM);
            reachable = !(root_miss || link_miss);
         end
      end else begin : g_open
         always_comb reachable = 1'b1;
      end
   endgenerate

   always_comb begin
      if (reachable)     disp = DISP_ACCESS;
      else if (is_write) disp = DISP_ERROR;
      else               disp = DISP_ONES;
   end

endmodule

// File: rtl/cfgx_route.sv
module cfgx_route
   import cfgx_pkg::*;
#(
   parameter int unsigned BUS_W           = 8,
   parameter int unsigned DEV_W           = 5,
   parameter int unsigned FN_W            = 3,
   parameter int unsigned OFF_W           = 12,
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned TYPE0_BUS_LIMIT = 2,
   parameter int unsigned ALIGN_BITS      = 2
) (
   input  logic [BUS_W-1:0]      bus,
   input  logic [DEV_W-1:0]      dev,
   input  logic [FN_W-1:0]       fn,
   input  logic [OFF_W-1:0]      off,
   output logic                  remote,
   output logic [CFG_TYPE_W-1:0] cfg_type,
   output logic [DATA_W-1:0]     target,
   output logic [OFF_W-1:0]      off_al
);

   localparam int unsigned SEL_W = BUS_W + DEV_W + FN_W;
   localparam int unsigned SHIFT = DATA_W - SEL_W;
   localparam logic [BUS_W-1:0] T0_LIM = BUS_W'(TYPE0_BUS_LIMIT);
   localparam logic [OFF_W-1:0] LOW_MASK = OFF_W'((1 << ALIGN_BITS) - 1);

   generate
      if (SEL_W > DATA_W) begin : g_bad_sel
         $error("cfgx_route: bus/device/function wider than target");
      end
      if (ALIGN_BITS >= OFF_W) begin : g_bad_align
         $error("cfgx_route: alignment swallows the offset");
      end
      if (TYPE0_BUS_LIMIT >= (1 << BUS_W)) begin : g_bad_lim
         $error("cfgx_route: type-0 bus limit does not fit BUS_W");
      end
   endgenerate

   logic [SEL_W-1:0] sel;

   always_comb begin
      sel      = {bus, dev, fn};
      remote   = (bus != '0);
      cfg_type = (bus < T0_LIM) ? CFG_TYPE0 : CFG_TYPE1;
      target   = '0;
      if (remote) target = DATA_W'(sel) << SHIFT;
      off_al   = off & ~LOW_MASK;
   end

endmodule

// File: rtl/cfgx_cpl_merge.sv
module cfgx_cpl_merge #(
   parameter int unsigned DATA_W  = 32,
   parameter bit          CPL_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpl_valid,
   input  logic              cpl_err,
   input  logic [DATA_W-1:0] cpl_data,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] merged;

   always_comb merged = cpl_err ? {DATA_W{1'b1}} : cpl_data;

   generate
      if (CPL_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_valid <= 1'b0;
               rd_data  <= '0;
            end else begin
               rd_valid <= cpl_valid;
               if (cpl_valid) rd_data <= merged;
            end
         end

         // R10: an errored completion returns all ones in the next cycle
         p_cpl_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (cpl_valid && cpl_err) |=> (rd_valid && (rd_data == {DATA_W{1'b1}})));

         // R10: completion valid is delayed by exactly one cycle
         p_cpl_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cpl_valid |=> rd_valid);
      end else begin : g_comb
         always_comb begin
            rd_valid = cpl_valid && rst_n;
            rd_data  = rst_n ? merged : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
   import cfgx_pkg::*;
#(
   parameter int unsigned BUS_W           = 8,
   parameter int unsigned DEV_W           = 5,
   parameter int unsigned FN_W            = 3,
   parameter int unsigned OFF_W           = 12,
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned TYPE0_BUS_LIMIT = 2,
   parameter int unsigned ROOT_DEV_MAX    = 1,
   parameter int unsigned LINK_DEV_MAX    = 0,
   parameter bit          FILTER_EN       = 1'b1,
   parameter bit          CPL_REG         = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [BUS_W-1:0]      req_bus,
   input  logic [DEV_W-1:0]      req_dev,
   input  logic [FN_W-1:0]       req_func,
   input  logic [OFF_W-1:0]      req_offset,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic                  cpl_valid,
   input  logic                  cpl_err,
   input  logic [DATA_W-1:0]     cpl_data,
   output logic                  rsp_valid,
   output logic                  rsp_access,
   output logic                  rsp_ones,
   output logic                  rsp_err,
   output logic                  rsp_remote,
   output logic [CFG_TYPE_W-1:0] rsp_type,
   output logic [DATA_W-1:0]     rsp_target,
   output logic [OFF_W-1:0]      rsp_offset,
   output logic [DATA_W-1:0]     rsp_wdata,
   output logic                  rd_valid,
   output logic [DATA_W-1:0]     rd_data
);

   localparam logic [BUS_W-1:0] T0_LIM   = BUS_W'(TYPE0_BUS_LIMIT);
   localparam logic [DEV_W-1:0] ROOT_LIM = DEV_W'(ROOT_DEV_MAX);
   localparam logic [OFF_W-1:0] LOW_MASK = OFF_W'(3);

   logic                  reach;
   disp_e                 disp;
   logic                  nx_remote;
   logic [CFG_TYPE_W-1:0] nx_type;
   logic [DATA_W-1:0]     nx_target;
   logic [OFF_W-1:0]      nx_offset;

   cfgx_filter #(
      .BUS_W       (BUS_W),
      .DEV_W       (DEV_W),
      .FILTER_EN   (FILTER_EN),
      .ROOT_DEV_MAX(ROOT_DEV_MAX),
      .LINK_DEV_MAX(LINK_DEV_MAX)
   ) u_filter (
      .bus      (req_bus),
      .dev      (req_dev),
      .is_write (req_write),
      .reachable(reach),
      .disp     (disp)
   );

   cfgx_route #(
      .BUS_W          (BUS_W),
      .DEV_W          (DEV_W),
      .FN_W           (FN_W),
      .OFF_W          (OFF_W),
      .DATA_W         (DATA_W),
      .TYPE0_BUS_LIMIT(TYPE0_BUS_LIMIT),
      .ALIGN_BITS     (2)
   ) u_route (
      .bus     (req_bus),
      .dev     (req_dev),
      .fn      (req_func),
      .off     (req_offset),
      .remote  (nx_remote),
      .cfg_type(nx_type),
      .target  (nx_target),
      .off_al  (nx_offset)
   );

   cfgx_cpl_merge #(
      .DATA_W (DATA_W),
      .CPL_REG(CPL_REG)
   ) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpl_valid(cpl_valid),
      .cpl_err  (cpl_err),
      .cpl_data (cpl_data),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_access <= 1'b0;
         rsp_ones   <= 1'b0;
         rsp_err    <= 1'b0;
         rsp_remote <= 1'b0;
         rsp_type   <= '0;
         rsp_target <= '0;
         rsp_offset <= '0;
         rsp_wdata  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_access <= (disp == DISP_ACCESS) && reach;
            rsp_ones   <= (disp == DISP_ONES);
            rsp_err    <= (disp == DISP_ERROR);
            rsp_remote <= nx_remote;
            rsp_type   <= nx_type;
            rsp_target <= nx_target;
            rsp_offset <= nx_offset;
            rsp_wdata  <= req_wdata;
         end
      end
   end

   // R1: one response per request, one cycle later
   p_rsp_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R4: a write past the root-bus device limit never proceeds
   p_write_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (FILTER_EN && req_valid && req_write && (req_bus == '0) && (req_dev > ROOT_LIM))
      |=> (rsp_err && !rsp_access));

   // R5: exactly one completion flag per response
   p_one_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_access, rsp_ones, rsp_err}) == 1));

   // R6: buses at or past the limit use type 1
   p_type1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_bus >= T0_LIM)) |=> (rsp_type == CFG_TYPE1));

   // R7: bus 0 stays in the local window with no target
   p_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_bus == '0)) |=> (!rsp_remote && (rsp_target == '0)));

   // R9: offset is always word aligned
   p_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((rsp_offset & LOW_MASK) == '0));

   // R11: fields hold while idle
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_target) && $stable(rsp_type) && $stable(rsp_offset)));

endmodule

// File: tb/cfgx_xlate_tb_top.sv
module cfgx_xlate_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [11:0] req_offset = '0;
   logic [31:0] req_wdata = '0;
   logic        cpl_valid = 1'b0;
   logic        cpl_err = 1'b0;
   logic [31:0] cpl_data = '0;
   logic        rsp_valid, rsp_access, rsp_ones, rsp_err, rsp_remote;
   logic [2:0]  rsp_type;
   logic [31:0] rsp_target;
   logic [11:0] rsp_offset;
   logic [31:0] rsp_wdata;
   logic        rd_valid;
   logic [31:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgx_xlate dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
      .req_dev(req_dev), .req_func(req_func), .req_offset(req_offset),
      .req_wdata(req_wdata),
      .cpl_valid(cpl_valid), .cpl_err(cpl_err), .cpl_data(cpl_data),
      .rsp_valid(rsp_valid), .rsp_access(rsp_access), .rsp_ones(rsp_ones),
      .rsp_err(rsp_err), .rsp_remote(rsp_remote), .rsp_type(rsp_type),
      .rsp_target(rsp_target), .rsp_offset(rsp_offset), .rsp_wdata(rsp_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                        input logic w, input logic [11:0] off, input logic [31:0] wd);
      logic        ok;
      logic [31:0] tgt;
      ok  = !((b == 8'd0 && d > 5'd1) || (b == 8'd1 && d > 5'd0));
      tgt = (b != 8'd0) ? {b, d, f, 16'h0000} : 32'h0;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_bus = b; req_dev = d;
      req_func = f; req_offset = off; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_write = ~w; req_bus = ~b; req_dev = ~d;
      req_func = ~f; req_offset = ~off; req_wdata = ~wd;
      chk("R1 rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R2 R5 access", 64'(rsp_access), 64'(ok));
      chk("R3 ones", 64'(rsp_ones), 64'(!ok && !w));
      chk("R4 err", 64'(rsp_err), 64'(!ok && w));
      chk("R6 type", 64'(rsp_type), (b < 8'd2) ? 64'h4 : 64'h5);
      chk("R7 remote", 64'(rsp_remote), 64'(b != 8'd0));
      chk("R8 target", 64'(rsp_target), 64'(tgt));
      chk("R9 offset", 64'(rsp_offset), 64'(off & 12'hFFC));
      chk("R9 wdata", 64'(rsp_wdata), 64'(wd));
      @(negedge clk);
      chk("R1 idle", 64'(rsp_valid), 64'd0);
      chk("R11 hold target", 64'(rsp_target), 64'(tgt));
      chk("R11 hold type/offset", 64'({rsp_type, rsp_offset}),
          64'({((b < 8'd2) ? 3'h4 : 3'h5), off & 12'hFFC}));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset valid", 64'(rsp_valid), 64'd0);
      chk("R1 reset target", 64'(rsp_target), 64'd0);
      chk("R1 reset rd", 64'({rd_valid, rd_data}), 64'd0);
      rst_n = 1'b1;
      for (int bi = 0; bi < 6; bi++) begin
         logic [7:0] b;
         case (bi)
            0: b = 8'd0;  1: b = 8'd1;  2: b = 8'd2;
            3: b = 8'd3;  4: b = 8'd127; default: b = 8'd255;
         endcase
         for (int d = 0; d < 32; d++) begin
            for (int w = 0; w < 2; w++) begin
               apply(b, 5'(d), 3'((d + bi) % 8), w[0],
                     12'((bi * 517 + d * 131 + w * 7) % 4096),
                     32'h9E37_79B9 * 32'(bi * 64 + d * 2 + w));
            end
         end
      end
      // R10: completions with and without error
      for (int k = 0; k < 16; k++) begin
         logic [31:0] dat;
         dat = 32'h1357_9BDF ^ (32'(k) * 32'h0101_0101);
         @(negedge clk);
         cpl_valid = 1'b1; cpl_err = k[0]; cpl_data = dat;
         @(negedge clk);
         cpl_valid = 1'b0; cpl_err = ~k[0]; cpl_data = ~dat;
         chk("R10 rd_valid", 64'(rd_valid), 64'd1);
         chk("R10 rd_data", 64'(rd_data), k[0] ? 64'hFFFF_FFFF : 64'(dat));
         @(negedge clk);
         chk("R10 rd idle", 64'(rd_valid), 64'd0);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule